// File: doc/BRIEF.md
# Binary/BCD Down Counter Core

This block is a down counter with a width of four decimal digits (16 bits at the default size). A control input selects whether the value is treated as plain binary or as packed BCD. A load strobe writes a new start value into the counter and also stores it as the reload value. Each enabled clock then lowers the count by a step of one, two or three, chosen per cycle. In free-running operation the count passes through zero and wraps to the top of its range. In periodic operation the stored start value is put back whenever a step would reach or cross zero.

All state changes on the falling clock edge, and reset is synchronous to that edge. A start value of zero is the largest count: 65536 in binary and 10000 in BCD. A single-cycle terminal flag marks every step that reaches or crosses zero. Output waveform shaping and gate handling belong to the surrounding logic.

Top module: `dncnt_core`

## Requirements
- R1: While `rst` is high at a falling clock edge, `count` becomes 0 and `tc` becomes 0.
- R2: When `load` is high at a falling edge, `count` takes `load_val`, the value is kept as the reload value, and `tc` is 0. This holds even if `dec_en` is high in the same cycle.
- R3: In binary mode (`bcd_mode`=0), each enabled falling edge lowers `count` by the step. The step is set by `step`: code 1 means one, code 2 means two, code 3 means three, and code 0 is treated as one.
- R4: In BCD mode (`bcd_mode`=1), each nibble is one decimal digit, with bits 3:0 as the units. A step subtracts decimally and borrows across digits, so every nibble stays in 0..9 when the loaded values were valid BCD.
- R5: A count of 0 stands for the full range. Stepping down from 0 gives 0x10000 minus the step in binary and 10000 minus the step in BCD, for example 0xFFFF or 0x9999 for a step of one. `tc` stays low on that step.
- R6: With `periodic`=0, a step that goes below zero wraps around: binary continues from 0xFFFF and BCD from 9999. For example, 2 minus 3 gives 0xFFFF or 0x9999.
- R7: With `periodic`=1, a step from a nonzero count that is at most the step size puts the stored reload value into `count` instead of the difference.
- R8: `tc` is high for the one cycle after a falling edge on which an enabled step started from a nonzero count and reached or crossed zero. It is low after every other edge.
- R9: With `load` and `dec_en` both low, `count` holds its value and `tc` is 0.
- R10: The reload value survives any number of steps and reloads. Only a new load changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for `load_val` |
| load_val | input | 16 | Start value, also stored as reload value |
| dec_en | input | 1 | Enables one step on this edge |
| step | input | 2 | Step size code (0 or 1: one, 2: two, 3: three) |
| bcd_mode | input | 1 | 1 selects BCD arithmetic, 0 binary |
| periodic | input | 1 | 1 selects reload on expiry, 0 wraparound |
| count | output | 16 | Current count |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bench aims at the digit-borrow chain: 1000 minus one in BCD must give 0999, not 0FFF or 09FF. A wrong correction constant or a broken borrow path would leave a nibble above nine. It also steps down from a count of zero. A design that treated zero as expired would wrongly reload or pulse `tc`, and one that lost the full-range meaning would stop there. Steps of two and three are fired across zero, both landing exactly on it and jumping past it. This exposes designs that only notice an exact zero, or that wrap to the wrong value in BCD. Finally, it asserts a load and a step in the same cycle and runs periodic reloads after long stretches of counting, to catch a step that wins over the load or a reload value that gets overwritten.

// File: rtl/dncnt_pkg.sv
`timescale 1ns/1ps
package dncnt_pkg;

    typedef enum logic [1:0] {
        STEP_DEF   = 2'd0,
        STEP_ONE   = 2'd1,
        STEP_TWO   = 2'd2,
        STEP_THREE = 2'd3
    } step_code_e;

    typedef enum logic {
        ARITH_BIN = 1'b0,
        ARITH_DEC = 1'b1
    } arith_e;

    typedef struct packed {
        logic hit_zero;
        logic crossed;
        logic expire;
        logic reload;
    } step_event_t;

    // step code to magnitude; the spare code behaves as a single step
    function automatic logic [1:0] step_amount(input logic [1:0] code);
        case (step_code_e'(code))
            STEP_TWO:   return 2'd2;
            STEP_THREE: return 2'd3;
            default:    return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/dncnt_bcd_digit.sv
`timescale 1ns/1ps
module dncnt_bcd_digit (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       bin,
    output logic [3:0] d,
    output logic       bout
);
    logic [4:0] raw;

    assign raw = {1'b0, a} - {1'b0, b} - {4'b0000, bin};

    always_comb begin
        bout = raw[4];
        // negative digit result: add ten (mod 16) to fold back into 0..9
        d    = raw[4] ? (raw[3:0] + 4'd10) : raw[3:0];
    end
endmodule

// File: rtl/dncnt_sub.sv
`timescale 1ns/1ps
module dncnt_sub #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val,
    input  logic [1:0]   amt,
    input  logic         bcd,
    output logic [W-1:0] diff,
    output logic         borrow
);
    import dncnt_pkg::*;

    logic [W:0]      bin_full;
    logic [W-1:0]    dec_diff;
    logic [DIGITS-1:0] brw;

    assign bin_full = {1'b0, val} - {{(W-1){1'b0}}, amt};

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_digit
            logic [3:0] sub_b;
            logic       sub_in;
            if (g == 0) begin : g_units
                assign sub_b  = {2'b00, amt};
                assign sub_in = 1'b0;
            end else begin : g_upper
                assign sub_b  = 4'd0;
                assign sub_in = brw[g-1];
            end
            dncnt_bcd_digit u_dig (
                .a    (val[4*g +: 4]),
                .b    (sub_b),
                .bin  (sub_in),
                .d    (dec_diff[4*g +: 4]),
                .bout (brw[g])
            );
        end
    endgenerate

    always_comb begin
        if (arith_e'(bcd) == ARITH_DEC) begin
            diff   = dec_diff;
            borrow = brw[DIGITS-1];
        end else begin
            diff   = bin_full[W-1:0];
            borrow = bin_full[W];
        end
    end
endmodule

// File: rtl/dncnt_core.sv
`timescale 1ns/1ps
module dncnt_core #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    input  logic [1:0]   step,
    input  logic         bcd_mode,
    input  logic         periodic,
    output logic [W-1:0] count,
    output logic         tc
);
    import dncnt_pkg::*;

    logic [W-1:0] count_q;
    logic [W-1:0] init_q;
    logic         tc_q;
    logic [W-1:0] next_diff;
    logic         next_borrow;
    logic [1:0]   amt;
    step_event_t  ev;

    assign amt = step_amount(step);

    dncnt_sub #(.DIGITS(DIGITS)) u_sub (
        .val    (count_q),
        .amt    (amt),
        .bcd    (bcd_mode),
        .diff   (next_diff),
        .borrow (next_borrow)
    );

    always_comb begin
        ev.hit_zero = (next_diff == '0);
        ev.crossed  = next_borrow;
        // a zero count means full range, so it never expires on this step
        ev.expire   = dec_en && (count_q != '0) && (ev.hit_zero || ev.crossed);
        ev.reload   = ev.expire && periodic;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            count_q <= '0;
            init_q  <= '0;
            tc_q    <= 1'b0;
        end else if (load) begin
            count_q <= load_val;
            init_q  <= load_val;
            tc_q    <= 1'b0;
        end else if (dec_en) begin
            count_q <= ev.reload ? init_q : next_diff;
            tc_q    <= ev.expire;
        end else begin
            tc_q    <= 1'b0;
        end
    end

    assign count = count_q;
    assign tc    = tc_q;

    function automatic logic digits_ok(input logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    // R2: load wins over a same-cycle step
    p_load_wins_r2: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (count_q == $past(load_val) && !tc_q));

    // R4: decimal steps keep every digit in range
    p_digits_in_range_r4: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && bcd_mode && $past(bcd_mode) && !$past(load)
         && digits_ok($past(count_q)) && digits_ok($past(init_q)))
        |-> digits_ok(count_q));

    // R7: a periodic expiry shows the stored start value
    p_reload_value_r7: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(periodic) && tc_q)
        |-> (count_q == $past(init_q)));

    // R8: the pulse only follows an enabled step from a nonzero count
    p_tc_cause_r8: assert property (@(negedge clk) disable iff (rst)
        tc_q |-> (!$past(rst) && $past(dec_en) && !$past(load) && ($past(count_q) != '0)));

    // R9: idle cycles hold the count
    p_idle_hold_r9: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && !$past(dec_en))
        |-> (count_q == $past(count_q) && !tc_q));

    // R10: reload value changes only through a load
    p_init_kept_r10: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> (init_q == $past(init_q)));
endmodule

// File: tb/dncnt_core_test.sv
`timescale 1ns/1ps
module dncnt_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_val = 16'h0;
    logic        dec_en = 1'b0;
    logic [1:0]  step = 2'd1;
    logic        bcd_mode = 1'b0;
    logic        periodic = 1'b0;
    logic [15:0] count;
    logic        tc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dncnt_core uut (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .dec_en(dec_en), .step(step), .bcd_mode(bcd_mode),
        .periodic(periodic), .count(count), .tc(tc)
    );

    // one falling (active) edge, then sample at the following rising edge
    task automatic tick();
        @(negedge clk);
        @(posedge clk);
    endtask

    task automatic check(string req, logic [15:0] exp_c, logic exp_tc);
        checks++;
        if (count !== exp_c || tc !== exp_tc) begin
            errors++;
            $display("FAIL %s: count=%h tc=%b expected count=%h tc=%b",
                     req, count, tc, exp_c, exp_tc);
        end
    endtask

    task automatic do_load(logic [15:0] v, logic with_dec);
        load = 1'b1; load_val = v; dec_en = with_dec;
        tick();
        load = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        check("R1 reset", 16'h0000, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_load_override();
        bcd_mode = 1'b0; periodic = 1'b0; step = 2'd1;
        do_load(16'h0005, 1'b1);
        check("R2 load wins", 16'h0005, 1'b0);
        dec_en = 1'b1; tick();
        check("R3 step one", 16'h0004, 1'b0);
    endtask

    task automatic t_binary_steps();
        bcd_mode = 1'b0; periodic = 1'b0; step = 2'd2;
        do_load(16'h0007, 1'b0);
        dec_en = 1'b1;
        tick(); check("R3 step two", 16'h0005, 1'b0);
        tick(); check("R3 step two", 16'h0003, 1'b0);
        tick(); check("R3 step two", 16'h0001, 1'b0);
        tick(); check("R6 wrap crossing", 16'hFFFF, 1'b1);
        tick(); check("R8 pulse ends", 16'hFFFD, 1'b0);
        step = 2'd3; tick(); check("R3 step three", 16'hFFFA, 1'b0);
        step = 2'd0; tick(); check("R3 code zero acts as one", 16'hFFF9, 1'b0);
        dec_en = 1'b0;
    endtask

    task automatic t_exact_zero();
        bcd_mode = 1'b0; periodic = 1'b0; step = 2'd3;
        do_load(16'h0003, 1'b0);
        dec_en = 1'b1;
        tick(); check("R8 lands on zero", 16'h0000, 1'b1);
        step = 2'd1; tick(); check("R5 zero is full range", 16'hFFFF, 1'b0);
        do_load(16'h0000, 1'b0);
        dec_en = 1'b1; step = 2'd2;
        tick(); check("R5 zero minus two", 16'hFFFE, 1'b0);
        dec_en = 1'b0;
    endtask

    task automatic t_bcd();
        bcd_mode = 1'b1; periodic = 1'b0; step = 2'd1;
        do_load(16'h1000, 1'b0);
        dec_en = 1'b1;
        tick(); check("R4 borrow chain", 16'h0999, 1'b0);
        step = 2'd3; tick(); check("R4 step three", 16'h0996, 1'b0);
        do_load(16'h0100, 1'b0);
        dec_en = 1'b1; step = 2'd2;
        tick(); check("R4 two digit borrow", 16'h0098, 1'b0);
        do_load(16'h0000, 1'b0);
        dec_en = 1'b1; step = 2'd1;
        tick(); check("R5 decimal full range", 16'h9999, 1'b0);
        do_load(16'h0000, 1'b0);
        dec_en = 1'b1; step = 2'd2;
        tick(); check("R5 decimal zero minus two", 16'h9998, 1'b0);
        do_load(16'h0002, 1'b0);
        dec_en = 1'b1; step = 2'd3;
        tick(); check("R6 decimal wrap", 16'h9999, 1'b1);
        dec_en = 1'b0;
    endtask

    task automatic t_periodic();
        bcd_mode = 1'b0; periodic = 1'b1; step = 2'd2;
        do_load(16'h0005, 1'b0);
        dec_en = 1'b1;
        tick(); check("R7 periodic", 16'h0003, 1'b0);
        tick(); check("R7 periodic", 16'h0001, 1'b0);
        tick(); check("R7 reload", 16'h0005, 1'b1);
        tick(); check("R7 after reload", 16'h0003, 1'b0);
        bcd_mode = 1'b1; step = 2'd3;
        do_load(16'h0010, 1'b0);
        dec_en = 1'b1;
        tick(); check("R7 decimal periodic", 16'h0007, 1'b0);
        tick(); check("R7 decimal periodic", 16'h0004, 1'b0);
        tick(); check("R7 decimal periodic", 16'h0001, 1'b0);
        tick(); check("R7 decimal reload", 16'h0010, 1'b1);
        for (int i = 0; i < 12; i++) tick();
        // 12 more steps: 3 full periods of 4, back to 0x0010 with a pulse
        check("R10 reload value kept", 16'h0010, 1'b1);
        tick(); check("R10 next period", 16'h0007, 1'b0);
        dec_en = 1'b0;
    endtask

    task automatic t_hold();
        dec_en = 1'b0; periodic = 1'b0; bcd_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step = 2'(i + 1);
            tick();
            check("R9 idle hold", 16'h0007, 1'b0);
        end
    endtask

    initial begin
        @(posedge clk);
        t_reset();
        t_load_override();
        t_binary_steps();
        t_exact_zero();
        t_bcd();
        t_periodic();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule